// File: doc/BRIEF.md
# Dual Serial DAC Chain Driver

This block updates two 10-bit serial DACs that share one chip select, one serial clock and one data line, with the data output of the first device feeding the second. A one-cycle start strobe captures an X value and a Y value. The block then lowers the chip select, shifts one continuous 32-bit frame most significant bit first, and raises the chip select again. The X device word goes out first and the Y device word last, so after the 32 clocks each device holds its own word.

Each 16-bit device word is four zero fill bits, then the 10 sample bits MSB first, then two zero pad bits. An internal clock-enable divider sets the serial rate. Every SCLK high phase and every SCLK low phase lasts `DIV` system clocks.

The controller is a five-state machine:
- `ST_IDLE`: chip select is high. A start moves it to `ST_SELECT`.
- `ST_SELECT`: chip select is low, SCLK is low and the first bit is set up. On a tick it moves to `ST_HIGH`.
- `ST_HIGH`: SCLK is high. On a tick it moves to `ST_LOW`, or after the last bit to `ST_TAIL`.
- `ST_LOW`: SCLK is low and the next bit is set up. On a tick it moves to `ST_HIGH`.
- `ST_TAIL`: SCLK is low and data is driven low. On a tick it moves to `ST_IDLE` and `done` pulses.

Top module: `dacpair_tx`

## Requirements
- R1: After reset, `cs_n` is 1 and `sclk`, `sdo`, `busy` and `done` are 0.
- R2: Each frame carries exactly 32 bits, sampled on rising `sclk`. The bit order is {4'b0000, X[9:0], 2'b00, 4'b0000, Y[9:0], 2'b00}, leftmost bit first.
- R3: Bits [15:10] of `x_in` and `y_in` have no effect on the frame.
- R4: `sclk` is 0 in the cycle before and in the cycle after every change of `cs_n`.
- R5: `sdo` never changes while `sclk` is 1.
- R6: Every `sclk` high phase and every `sclk` low phase inside a frame lasts exactly `DIV` clock cycles.
- R7: `sdo` is 0 in the last cycle before `cs_n` rises.
- R8: A `start` pulse while `busy` is 1 is ignored. No extra frame follows, and `cs_n` stays high after the current frame ends.
- R9: X and Y are captured in the cycle `start` is accepted. Later input changes do not alter the frame in progress.
- R10: `done` is 1 for exactly one cycle, in the first cycle where `cs_n` is back at 1.
- R11: In the cycle after `start` is accepted from idle, `cs_n` is 0 and `busy` is 1. `busy` stays 1 until `cs_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to send a frame |
| x_in | input | 16 | X sample; only bits [9:0] are used |
| y_in | input | 16 | Y sample; only bits [9:0] are used |
| cs_n | output | 1 | Shared chip select, active low |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data, MSB first |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the frame ends |

## Verification
Most internal faults surface within the frame where they occur.
- A wrong bit counter or shift register gives a frame of the wrong length, or with bits in the wrong places. The frame scoreboard reports this at the rising edge of the chip select that closes the frame.
- A state machine that moves on a wrong tick shows up as an SCLK phase that is not `DIV` cycles long, within one phase.
- A wrong decode of the data register shows up as data moving while SCLK is high, or as data left high at release.
- A missed busy guard starts a second frame, which appears as an unexpected frame or as an unexpected chip-select fall.

// File: rtl/dacpair_pkg.sv
package dacpair_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } dac_state_t;

    localparam int DEV_COUNT = 2;

endpackage

// File: rtl/dacpair_rate.sv
module dacpair_rate #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !clr && (cnt_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6

endmodule

// File: rtl/dacpair_shifter.sv
module dacpair_shifter #(
    parameter int IN_W   = 16,
    parameter int VAL_W  = 10,
    parameter int FILL_W = 4,
    parameter int PAD_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic [IN_W-1:0] x_in,
    input  logic [IN_W-1:0] y_in,
    output logic            msb
);
    import dacpair_pkg::*;

    localparam int WORD_W  = FILL_W + VAL_W + PAD_W;
    localparam int FRAME_W = WORD_W * DEV_COUNT;

    logic [VAL_W-1:0]   dev_val [DEV_COUNT];
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] shreg_q;

    // device 0 (X) goes out first, so it occupies the top word
    assign dev_val[0] = x_in[VAL_W-1:0];
    assign dev_val[1] = y_in[VAL_W-1:0];

    for (genvar d = 0; d < DEV_COUNT; d++) begin : g_word
        assign frame[FRAME_W-1-d*WORD_W -: WORD_W] =
            {{FILL_W{1'b0}}, dev_val[d], {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= frame;
        end else if (shift) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign msb = shreg_q[FRAME_W-1];

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R2

endmodule

// File: rtl/dacpair_ctrl.sv
module dacpair_ctrl #(
    parameter int FRAME_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic bit_msb,
    output logic load,
    output logic shift,
    output logic cnt_clr,
    output logic cs_n,
    output logic sclk,
    output logic sdo,
    output logic busy,
    output logic done
);
    import dacpair_pkg::*;

    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    dac_state_t state_q, state_d;
    logic [BW-1:0] bitcnt_q;
    logic          sdo_q;
    logic          done_q;
    logic          last_bit;

    assign last_bit = (bitcnt_q == LAST_BIT);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SELECT;
            ST_SELECT: if (tick)  state_d = ST_HIGH;
            ST_HIGH:   if (tick)  state_d = last_bit ? ST_TAIL : ST_LOW;
            ST_LOW:    if (tick)  state_d = ST_HIGH;
            ST_TAIL:   if (tick)  state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load    = (state_q == ST_IDLE) && start;
    assign shift   = (state_q == ST_HIGH) && tick && !last_bit;
    assign cnt_clr = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n)     bitcnt_q <= '0;
        else if (load)  bitcnt_q <= '0;
        else if (shift) bitcnt_q <= bitcnt_q + 1'b1;
    end

    // data register: updated only while SCLK is low, one cycle after a shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_TAIL) && tick;
            unique case (state_q)
                ST_SELECT, ST_LOW: sdo_q <= bit_msb;
                ST_HIGH:           sdo_q <= sdo_q;
                ST_IDLE, ST_TAIL:  sdo_q <= 1'b0;
                default:           sdo_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        cs_n = (state_q == ST_IDLE);
        sclk = (state_q == ST_HIGH);
        busy = (state_q != ST_IDLE);
        sdo  = sdo_q;
        done = done_q;
    end

    AST_CS_EDGE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) || $fell(cs_n)) |-> (!sclk && !$past(sclk))); // R4
    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo)); // R5
    AST_SDO_LOW_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !$past(sdo)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n))); // R10
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !load); // R8

endmodule

// File: rtl/dacpair_tx.sv
module dacpair_tx #(
    parameter int DIV    = 4,
    parameter int IN_W   = 16,
    parameter int VAL_W  = 10,
    parameter int FILL_W = 4,
    parameter int PAD_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IN_W-1:0] x_in,
    input  logic [IN_W-1:0] y_in,
    output logic            cs_n,
    output logic            sclk,
    output logic            sdo,
    output logic            busy,
    output logic            done
);
    import dacpair_pkg::*;

    localparam int FRAME_W = (FILL_W + VAL_W + PAD_W) * DEV_COUNT;

    logic tick, load, shift, cnt_clr, bit_msb;

    dacpair_rate #(.DIV(DIV)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick)
    );

    dacpair_shifter #(
        .IN_W(IN_W), .VAL_W(VAL_W), .FILL_W(FILL_W), .PAD_W(PAD_W)
    ) u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .x_in  (x_in),
        .y_in  (y_in),
        .msb   (bit_msb)
    );

    dacpair_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .bit_msb (bit_msb),
        .load    (load),
        .shift   (shift),
        .cnt_clr (cnt_clr),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdo     (sdo),
        .busy    (busy),
        .done    (done)
    );

endmodule

// File: tb/dacpair_tx_bench.sv
module dacpair_tx_bench;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic cs_n, sclk, sdo, busy, done;

    int n_checks = 0;
    int n_fail = 0;
    int frames_seen = 0;
    int frames_sent = 0;
    logic [31:0] exp_q [$];

    always #2.5 clk = ~clk;

    dacpair_tx #(.DIV(DIV)) u_dacpair_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_frame(input logic [15:0] x, input logic [15:0] y);
        return {4'b0000, x[9:0], 2'b00, 4'b0000, y[9:0], 2'b00};
    endfunction

    // driver: pushes the expected frame and starts a transfer
    task automatic send(input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        x_in = x; y_in = y; start = 1'b1;
        exp_q.push_back(model_frame(x, y));
        frames_sent++;
        @(negedge clk);
        start = 1'b0;
        check(!cs_n && busy, "R11 select/busy after start", {30'd0, cs_n, busy}, 32'h1);
        while (!done) @(negedge clk);
    endtask

    // monitor
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_sdo = 1'b0;
    logic [31:0] got = '0;
    int nbits = 0;
    int phase_len = 0;
    bit bad_r5 = 0, bad_r6 = 0, bad_r4 = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n != prev_cs && (sclk || prev_sclk)) bad_r4 = 1;
            if (!prev_cs && !cs_n) begin
                if (sclk && prev_sclk && sdo != prev_sdo) bad_r5 = 1;
                if (sclk != prev_sclk) begin
                    if (phase_len != DIV) bad_r6 = 1;
                    phase_len = 1;
                end else begin
                    phase_len++;
                end
            end
            if (prev_cs && !cs_n) begin
                nbits = 0; got = '0; phase_len = 1;
                bad_r5 = 0; bad_r6 = 0; bad_r4 = 0;
            end
            if (sclk && !prev_sclk && !cs_n) begin
                got = {got[30:0], sdo};
                nbits++;
            end
            if (done && !(cs_n && !prev_cs))
                check(0, "R10 done outside release", 32'd1, 32'd0);
            if (!prev_cs && cs_n) begin
                logic [31:0] exp_f;
                frames_seen++;
                check(done, "R10 done at release", {31'd0, done}, 32'd1);
                check(!prev_sdo, "R7 sdo low before release", {31'd0, prev_sdo}, 32'd0);
                check(nbits == 32, "R2 bit count", nbits, 32);
                check(!bad_r4, "R4 sclk low at cs edge", {31'd0, bad_r4}, 32'd0);
                check(!bad_r5, "R5 sdo stable while sclk high", {31'd0, bad_r5}, 32'd0);
                check(!bad_r6, "R6 phase length", {31'd0, bad_r6}, 32'd0);
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected frame", got, 32'hx);
                end else begin
                    exp_f = exp_q.pop_front();
                    check(got == exp_f, "R2 R3 R9 frame content", got, exp_f);
                end
            end
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_sdo = sdo;
    end

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog expired", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(cs_n && !sclk && !sdo && !busy && !done, "R1 reset state",
              {27'd0, cs_n, sclk, sdo, busy, done}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !busy, "R1 idle after reset", {30'd0, cs_n, busy}, 32'h2);

        send(16'h03FF, 16'h0000);                 // R2
        send(16'h0000, 16'h03FF);                 // R2
        send(16'h0155, 16'h02AA);                 // R2
        send(16'hFC01, 16'hA802);                 // R3 upper bits ignored
        send(16'hFFFF, 16'hFC00);                 // R3

        // R8 / R9: new start and input changes mid-frame
        @(negedge clk);
        x_in = 16'h0201; y_in = 16'h0102; start = 1'b1;
        exp_q.push_back(model_frame(16'h0201, 16'h0102));
        frames_sent++;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        x_in = 16'h0111; y_in = 16'h0333; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        x_in = 16'h03C3; y_in = 16'h0001;
        while (!done) @(negedge clk);
        begin
            bit stayed = 1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!cs_n || busy) stayed = 0;
            end
            check(stayed, "R8 no frame after ignored start", {31'd0, stayed}, 32'd1);
        end

        // back-to-back frames
        send(16'h0200, 16'h0001);
        send(16'h0001, 16'h0200);

        repeat (5) @(negedge clk);
        check(frames_seen == frames_sent, "R8 frame count", frames_seen, frames_sent);
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 32'd0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule